// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block chooses the next program counter for a core that runs hardware repeat loops. A setup command arms a loop by loading a first-word address, a last-word address and an iteration count, all in one cycle. After that, the loop runs back to its first word each time the last word retires, and no branch instruction is needed. The count drops by one on every pass through the last word. When it reaches zero the loop disarms and execution continues past the last word.

Each retiring instruction packet tells the block whether it redirected the program counter, and if so, to where. The block picks the next PC in this order of priority. First comes the redirect target. Next comes the loop start, when the armed loop's last word retires with passes left. Otherwise the PC moves on by one word. The PC is a word address. Loop addresses arrive as byte addresses and are turned into word addresses by dropping the two low bits. Fetch, branch resolution and decoding of the setup instruction sit outside this block.

Top module: `rpt_loop_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `pc` equal to `reset_vec`, `loop_active` low and `loop_count` zero.
- R2: A setup command (`setup_valid` high) with a nonzero count loads `setup_count` into `loop_count` and sets `loop_active` on the next cycle. The start and end word addresses are byte address bits [PC_W+1:2], and byte address bits [1:0] are ignored.
- R3: A setup command with a count of zero leaves `loop_active` low, even if a loop was armed. A later retire at the old end address then advances the PC by one.
- R4: In a cycle without `retire_valid`, `pc`, `loop_active` and `loop_count` keep their values.
- R5: A retiring packet with `redirect_valid` high sets `pc` to `redirect_pc`, even when `pc` equals the loop end address. The loop count does not change.
- R6: A retiring packet that does not redirect and is not a loop-back advances `pc` by one, modulo 2^PC_W.
- R7: When the loop is armed and a packet retires without a redirect at the end address while `loop_count` is greater than one, `loop_count` drops by one and `pc` becomes the loop start address.
- R8: When the loop is armed and a packet retires without a redirect at the end address while `loop_count` is one, `loop_count` becomes zero, `loop_active` clears and `pc` becomes the end address plus one.
- R9: While the loop is not armed, retiring at the stored end address advances `pc` by one.
- R10: A redirect out of the loop body leaves `loop_active` and `loop_count` unchanged. A later pass through the end address still loops back.
- R11: When a setup command and a retiring packet fall in the same cycle, `pc` follows the loop state from before the setup. The loop registers take the setup values, and the setup wins over any decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | PC_W | Word address loaded into the PC on reset |
| setup_valid | input | 1 | Setup command: arm the loop with the values below |
| setup_start_addr | input | PC_W+2 | Byte address of the first loop word |
| setup_end_addr | input | PC_W+2 | Byte address of the last loop word |
| setup_count | input | CNT_W | Number of passes through the loop |
| retire_valid | input | 1 | An instruction packet retires this cycle |
| redirect_valid | input | 1 | The retiring packet changed the PC |
| redirect_pc | input | PC_W | Word address the retiring packet jumped to |
| pc | output | PC_W | Current word-address program counter |
| loop_active | output | 1 | A repeat loop is armed |
| loop_count | output | CNT_W | Passes left in the armed loop |

## Verification
The bench runs a sweep over loop lengths of one to four words and counts of one to seven, with idle cycles placed among the retires. A design that is off by one on the count would run one pass too many or too few. A design that compares against the byte address instead of the word address would never loop back at all. A set of corner cases covers the remaining rules: a redirect at the end address must win over the loop-back, or the loop would swallow the branch; a branch out of the body must not disarm the loop; an unarmed loop must ignore its stale end address; a count of zero must not arm; the PC must wrap at the top of the address space; and a setup in a retire cycle must beat the decrement, or the new loop would start one pass short.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int unsigned PC_W_DEFAULT  = 16;
    localparam int unsigned CNT_W_DEFAULT = 16;

    // Number of low byte-address bits that select a byte within a 32-bit word
    localparam int unsigned WORD_SHIFT = 2;

    // Source of the next program counter
    typedef enum logic [1:0] {
        NPC_HOLD   = 2'd0,
        NPC_TARGET = 2'd1,
        NPC_LOOP   = 2'd2,
        NPC_SEQ    = 2'd3
    } npc_sel_e;

    // Pick the next-PC source from the retire event and the loop decision
    function automatic npc_sel_e pick_source(
        input logic retire,
        input logic redirect,
        input logic end_hit,
        input logic last_pass
    );
        npc_sel_e sel;
        if (!retire)                     sel = NPC_HOLD;
        else if (redirect)               sel = NPC_TARGET;
        else if (end_hit && !last_pass)  sel = NPC_LOOP;
        else                             sel = NPC_SEQ;
        return sel;
    endfunction

endpackage

// File: rtl/rpt_loop_regs.sv
module rpt_loop_regs
    import rpt_pkg::*;
#(
    parameter int unsigned PC_W  = PC_W_DEFAULT,
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             setup_valid,
    input  logic [PC_W+1:0]  setup_start_addr,
    input  logic [PC_W+1:0]  setup_end_addr,
    input  logic [CNT_W-1:0] setup_count,
    input  logic             end_hit,
    output logic             active,
    output logic [PC_W-1:0]  start_word,
    output logic [PC_W-1:0]  end_word,
    output logic [CNT_W-1:0] count,
    output logic             last_pass
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PC_W-1:0] setup_start_word;
    logic [PC_W-1:0] setup_end_word;
    logic            setup_arms;

    assign setup_start_word = setup_start_addr[PC_W+1:WORD_SHIFT];
    assign setup_end_word   = setup_end_addr[PC_W+1:WORD_SHIFT];
    assign setup_arms       = (setup_count != '0);
    assign last_pass        = (count == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            start_word <= '0;
            end_word   <= '0;
            count      <= '0;
        end else if (setup_valid) begin
            active     <= setup_arms;
            start_word <= setup_start_word;
            end_word   <= setup_end_word;
            count      <= setup_count;
        end else if (end_hit) begin
            count <= count - CNT_ONE;
            if (last_pass) begin
                active <= 1'b0;
            end
        end
    end

    // R2: an armed loop always has passes left
    a_r2_armed_has_passes: assert property (@(posedge clk) disable iff (rst)
        active |-> (count != '0));

    // R3: a zero-count setup never arms
    a_r3_zero_count_idle: assert property (@(posedge clk) disable iff (rst)
        (setup_valid && (setup_count == '0)) |=> !active);

    // R7: a pass with passes left counts down and stays armed
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !setup_valid && (count > CNT_ONE)) |=>
            (active && (count == $past(count) - CNT_ONE)));

    // R8: the final pass disarms with an empty count
    a_r8_final_pass: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !setup_valid && (count == CNT_ONE)) |=>
            (!active && (count == '0)));

    // R11: setup wins over a same-cycle decrement
    a_r11_setup_wins: assert property (@(posedge clk) disable iff (rst)
        setup_valid |=> (count == $past(setup_count)));

endmodule

// File: rtl/rpt_end_detect.sv
module rpt_end_detect
    import rpt_pkg::*;
#(
    parameter int unsigned PC_W = PC_W_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire_valid,
    input  logic            redirect_valid,
    input  logic            active,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] end_word,
    output logic            end_hit
);

    logic at_end;
    logic sequential_retire;

    assign at_end            = (pc == end_word);
    assign sequential_retire = retire_valid && !redirect_valid;
    assign end_hit           = sequential_retire && active && at_end;

    // R9: a disarmed loop never takes a pass, whatever the stored end address
    a_r9_idle_no_pass: assert property (@(posedge clk) disable iff (rst)
        (!active && retire_valid) |-> !end_hit);

    // R5: a redirecting packet never counts as a pass
    a_r5_redirect_no_pass: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !end_hit);

endmodule

// File: rtl/rpt_next_pc.sv
module rpt_next_pc
    import rpt_pkg::*;
#(
    parameter int unsigned PC_W = PC_W_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] reset_vec,
    input  logic            retire_valid,
    input  logic            redirect_valid,
    input  logic [PC_W-1:0] redirect_pc,
    input  logic            end_hit,
    input  logic            last_pass,
    input  logic [PC_W-1:0] start_word,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    npc_sel_e        sel;
    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] pc_next;

    assign sel    = pick_source(retire_valid, redirect_valid, end_hit, last_pass);
    assign pc_seq = pc + PC_STEP;

    always_comb begin
        unique case (sel)
            NPC_TARGET: pc_next = redirect_pc;
            NPC_LOOP:   pc_next = start_word;
            NPC_SEQ:    pc_next = pc_seq;
            default:    pc_next = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= reset_vec;
        end else begin
            pc <= pc_next;
        end
    end

    // R4: no retire, no movement
    a_r4_hold_pc: assert property (@(posedge clk) disable iff (rst)
        !retire_valid |=> $stable(pc));

    // R5: a redirect lands on its target
    a_r5_take_target: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && redirect_valid) |=> (pc == $past(redirect_pc)));

    // R6: a plain retire steps one word
    a_r6_step_word: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && !redirect_valid && !end_hit) |=>
            (pc == PC_W'($past(pc) + PC_STEP)));

    // R7: a pass with passes left jumps back to the start
    a_r7_jump_back: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !last_pass) |=> (pc == $past(start_word)));

    // R8: the final pass falls through
    a_r8_fall_through: assert property (@(posedge clk) disable iff (rst)
        (end_hit && last_pass) |=> (pc == PC_W'($past(pc) + PC_STEP)));

endmodule

// File: rtl/rpt_loop_ctrl.sv
module rpt_loop_ctrl
    import rpt_pkg::*;
#(
    parameter int unsigned PC_W  = PC_W_DEFAULT,
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  reset_vec,
    input  logic             setup_valid,
    input  logic [PC_W+1:0]  setup_start_addr,
    input  logic [PC_W+1:0]  setup_end_addr,
    input  logic [CNT_W-1:0] setup_count,
    input  logic             retire_valid,
    input  logic             redirect_valid,
    input  logic [PC_W-1:0]  redirect_pc,
    output logic [PC_W-1:0]  pc,
    output logic             loop_active,
    output logic [CNT_W-1:0] loop_count
);

    logic            end_hit;
    logic            last_pass;
    logic [PC_W-1:0] start_word;
    logic [PC_W-1:0] end_word;

    rpt_loop_regs #(
        .PC_W  (PC_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk              (clk),
        .rst              (rst),
        .setup_valid      (setup_valid),
        .setup_start_addr (setup_start_addr),
        .setup_end_addr   (setup_end_addr),
        .setup_count      (setup_count),
        .end_hit          (end_hit),
        .active           (loop_active),
        .start_word       (start_word),
        .end_word         (end_word),
        .count            (loop_count),
        .last_pass        (last_pass)
    );

    rpt_end_detect #(
        .PC_W (PC_W)
    ) u_detect (
        .clk            (clk),
        .rst            (rst),
        .retire_valid   (retire_valid),
        .redirect_valid (redirect_valid),
        .active         (loop_active),
        .pc             (pc),
        .end_word       (end_word),
        .end_hit        (end_hit)
    );

    rpt_next_pc #(
        .PC_W (PC_W)
    ) u_npc (
        .clk            (clk),
        .rst            (rst),
        .reset_vec      (reset_vec),
        .retire_valid   (retire_valid),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .end_hit        (end_hit),
        .last_pass      (last_pass),
        .start_word     (start_word),
        .pc             (pc)
    );

    // R1: reset loads the vector and disarms the loop
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> ((pc == $past(reset_vec)) && !loop_active && (loop_count == '0)));

    // R10: a redirect without setup leaves the loop state alone
    a_r10_branch_keeps_loop: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && redirect_valid && !setup_valid) |=>
            ($stable(loop_active) && $stable(loop_count)));

endmodule

// File: tb/test_rpt_loop_ctrl.sv
module test_rpt_loop_ctrl;

    localparam int PW = 6;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] reset_vec = PW'(5);
    logic          setup_valid = 1'b0;
    logic [PW+1:0] setup_start_addr = '0;
    logic [PW+1:0] setup_end_addr = '0;
    logic [CW-1:0] setup_count = '0;
    logic          retire_valid = 1'b0;
    logic          redirect_valid = 1'b0;
    logic [PW-1:0] redirect_pc = '0;
    logic [PW-1:0] pc;
    logic          loop_active;
    logic [CW-1:0] loop_count;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [PW-1:0] m_pc, m_start, m_end;
    logic [CW-1:0] m_cnt;
    bit            m_act;

    always #2 clk = ~clk;

    rpt_loop_ctrl #(.PC_W(PW), .CNT_W(CW)) i_rpt_loop_ctrl (
        .clk (clk), .rst (rst), .reset_vec (reset_vec),
        .setup_valid (setup_valid), .setup_start_addr (setup_start_addr),
        .setup_end_addr (setup_end_addr), .setup_count (setup_count),
        .retire_valid (retire_valid), .redirect_valid (redirect_valid),
        .redirect_pc (redirect_pc), .pc (pc), .loop_active (loop_active),
        .loop_count (loop_count)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "pc", int'(pc), int'(m_pc));
        check(tag, "loop_active", int'(loop_active), int'(m_act));
        check(tag, "loop_count", int'(loop_count), int'(m_cnt));
    endtask

    // One cycle: drive at the falling edge, compare at the next falling edge
    task automatic step(input bit ret, input bit rd, input logic [PW-1:0] tgt,
                        input bit su, input logic [PW+1:0] sa, input logic [PW+1:0] ea,
                        input logic [CW-1:0] sc, input string tag_in);
        string         tag;
        logic [PW-1:0] n_pc;
        bit            n_act;
        logic [CW-1:0] n_cnt;
        n_pc = m_pc; n_act = m_act; n_cnt = m_cnt; tag = "R4";
        if (ret) begin
            if (rd) begin
                n_pc = tgt; tag = "R5";
            end else if (m_act && m_pc == m_end) begin
                n_cnt = m_cnt - CW'(1);
                if (n_cnt == '0) begin
                    n_act = 1'b0; n_pc = m_pc + PW'(1); tag = "R8";
                end else begin
                    n_pc = m_start; tag = "R7";
                end
            end else begin
                n_pc = m_pc + PW'(1); tag = "R6";
            end
        end
        if (su) begin
            m_start = sa[PW+1:2];
            m_end   = ea[PW+1:2];
            n_cnt   = sc;
            n_act   = (sc != '0);
            tag     = ret ? "R11" : ((sc == '0) ? "R3" : "R2");
        end
        if (tag_in != "") tag = tag_in;
        retire_valid = ret; redirect_valid = rd; redirect_pc = tgt;
        setup_valid = su; setup_start_addr = sa; setup_end_addr = ea; setup_count = sc;
        @(posedge clk);
        @(negedge clk);
        retire_valid = 1'b0; redirect_valid = 1'b0; setup_valid = 1'b0;
        m_pc = n_pc; m_act = n_act; m_cnt = n_cnt;
        compare(tag);
    endtask

    task automatic retire(input string tag);
        step(1'b1, 1'b0, '0, 1'b0, '0, '0, '0, tag);
    endtask
    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, '0, '0, '0, "R4");
    endtask
    task automatic jump(input logic [PW-1:0] tgt, input string tag);
        step(1'b1, 1'b1, tgt, 1'b0, '0, '0, '0, tag);
    endtask
    task automatic setup(input int sw, input int ew, input int c, input int low);
        step(1'b0, 1'b0, '0, 1'b1, (PW+2)'(sw * 4 + low), (PW+2)'(ew * 4 + low), CW'(c), "");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        m_pc = reset_vec; m_act = 1'b0; m_cnt = '0; m_start = '0; m_end = '0;
        compare("R1");
        rst = 1'b0;

        // sequential and idle
        retire("R6"); idle(); retire("R6");

        // wrap at the top of the address space
        jump(PW'(63), "R5"); retire("R6");

        // sweep loop length and count; low byte bits vary (R2)
        for (int c = 1; c <= 7; c++) begin
            for (int len = 1; len <= 4; len++) begin
                setup(12, 12 + len - 1, c, (c + len) % 4);
                jump(PW'(12), "R5");
                for (int k = 0; k < c * len + 2; k++) begin
                    if (k % 5 == 3) idle();
                    retire("");
                end
            end
        end

        // stale end address with the loop disarmed
        jump(PW'(15), "R9"); retire("R9");

        // branch out of the body keeps the loop armed
        setup(20, 23, 3, 0);
        jump(PW'(20), "R10"); retire(""); retire("");
        jump(PW'(40), "R10"); retire("R10");
        jump(PW'(23), "R10"); retire("R10");
        for (int k = 0; k < 9; k++) retire("");

        // redirect at the end address beats the loop-back
        setup(30, 31, 2, 1);
        jump(PW'(31), "R5");
        jump(PW'(50), "R5");
        jump(PW'(31), "R5"); retire("R7");

        // zero count disarms a running loop
        setup(30, 31, 0, 0);
        jump(PW'(31), "R3"); retire("R3");

        // setup in a retire cycle at the end address
        setup(8, 9, 4, 0);
        jump(PW'(9), "R11");
        step(1'b1, 1'b0, '0, 1'b1, (PW+2)'(44 * 4), (PW+2)'(46 * 4), CW'(2), "R11");
        jump(PW'(46), "R11"); retire("R11"); retire("R11"); retire("R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule